// File: doc/BRIEF.md
# Modulo Timer Counter with Byte-Wide Register Access

This block is a 16-bit up-counter. It wraps at a programmable limit and raises an overflow flag each time it wraps. The limit is held as two byte registers, so software on an 8-bit register bus can change it. The counter moves one step on each clock cycle where the timer-tick enable is high and the freeze input is low. A separate strobe sends the count back to zero at any time.

A 16-bit limit is written over an 8-bit bus one byte at a time. Writing the upper limit byte therefore opens a hold window. While that window is open, wraps do not set the flag and the interrupt line stays low. Writing the lower byte closes the window. A half-updated limit can still make the counter wrap, but it cannot produce a false overflow event. Software clears the flag in two steps: it reads the status register while the flag is set, then writes a zero to the flag bit.

Top module: `modtmr_top`

## Requirements
- R1: After reset, both limit bytes read 0xFF, the count reads 0x0000, and the status register reads 0x00. Register addresses are: 0 status, 1 limit upper byte, 2 limit lower byte, 3 count upper byte, 4 count lower byte. Status layout: bit 7 is the overflow flag, bit 6 is the interrupt enable, bit 5 is the hold window, and the other bits read as 0.
- R2: On an advancing cycle (tick high, freeze low, clear strobe low), the count rises by one. If the count already equals the limit, it goes to 0x0000 instead. After N advancing cycles from zero, the count is N mod (limit+1).
- R3: A wrap sets the overflow flag unless the hold window is open.
- R4: A write to the upper limit byte opens the hold window. A write to the lower limit byte closes it. While the window is open, wraps still return the count to zero.
- R5: The interrupt output is high exactly when the flag is set, the enable bit is set, and the hold window is closed.
- R6: The flag clears only when status is written with bit 7 at 0 after status was read while the flag was set. Without that earlier read, the write leaves the flag set. Writing bit 7 as 1 never sets the flag.
- R7: A wrap in the same cycle as a clearing write leaves the flag set.
- R8: While the freeze input is high, the count holds its value even when tick is high.
- R9: The clear strobe forces the count to 0x0000 on the next edge. It has priority over tick and freeze, and it leaves both limit bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Timer step enable |
| freeze | input | 1 | Holds the count |
| cnt_clr | input | 1 | Count-to-zero strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (used to arm the flag clear) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions check four rules on every cycle: the wrap of the count to zero, the freeze and clear-strobe effects on the count, the rule that the flag cannot rise or be cleared outside the allowed cases, and the rule that no interrupt appears while the hold window is open. Other behaviour shows up only in the bench's scenarios. This includes the count modulo (limit+1) over long tick runs, the full read-then-write clear sequence, a wrap colliding with a clearing write, and a limit that survives the clear strobe.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int FLAG_BIT = 7;
    localparam int IE_BIT   = 6;
    localparam int HOLD_BIT = 5;

    typedef enum logic [ADDR_W-1:0] {
        RA_STAT = 3'd0,
        RA_LIMH = 3'd1,
        RA_LIML = 3'd2,
        RA_CNTH = 3'd3,
        RA_CNTL = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic flag;
        logic ie;
        logic hold;
    } stat_t;

    function automatic logic [BYTE_W-1:0] pack_status(stat_t s);
        logic [BYTE_W-1:0] v;
        v = '0;
        v[FLAG_BIT] = s.flag;
        v[IE_BIT]   = s.ie;
        v[HOLD_BIT] = s.hold;
        return v;
    endfunction
endpackage

// File: rtl/modtmr_limit.sv
module modtmr_limit
    import modtmr_pkg::*;
#(
    parameter int BW = BYTE_W,
    localparam int CW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hi,
    input  logic          wr_lo,
    input  logic [BW-1:0] wdata,
    output logic [CW-1:0] limit,
    output logic          hold
);
    logic [BW-1:0] hi_q, lo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '1;
            lo_q <= '1;
            hold <= 1'b0;
        end else begin
            if (wr_hi) begin
                hi_q <= wdata;
                hold <= 1'b1;
            end
            if (wr_lo) begin
                lo_q <= wdata;
                hold <= 1'b0;
            end
        end
    end

    assign limit = {hi_q, lo_q};
endmodule

// File: rtl/modtmr_count.sv
module modtmr_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          freeze,
    input  logic          clr,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count,
    output logic          wrap
);
    logic step;

    assign step = tick && !freeze && !clr;
    assign wrap = step && (count == limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            count <= '0;
        else if (wrap)
            count <= '0;
        else if (step)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/modtmr_flag.sv
module modtmr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic rd_stat,
    input  logic wr_stat,
    input  logic wr_flag_bit,
    input  logic wr_ie_bit,
    output logic flag,
    output logic ie
);
    logic armed;
    logic clr_ok;

    assign clr_ok = wr_stat && !wr_flag_bit && armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
            ie    <= 1'b0;
        end else begin
            if (wr_stat)
                ie <= wr_ie_bit;
            if (set_ev) begin
                flag <= 1'b1;
                if (clr_ok)
                    armed <= 1'b0;
            end else if (clr_ok) begin
                flag  <= 1'b0;
                armed <= 1'b0;
            end
            if (rd_stat && flag && !clr_ok)
                armed <= 1'b1;
        end
    end
endmodule

// File: rtl/modtmr_top.sv
module modtmr_top
    import modtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              freeze,
    input  logic              cnt_clr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic              irq
);
    localparam int CW = 2 * BYTE_W;

    logic [CW-1:0] limit;
    logic [CW-1:0] count;
    logic          hold;
    logic          wrap;
    logic          flag;
    logic          ie;
    stat_t         st;

    modtmr_limit #(.BW(BYTE_W)) u_limit (
        .clk   (clk),
        .rst   (rst),
        .wr_hi (wr_en && addr == RA_LIMH),
        .wr_lo (wr_en && addr == RA_LIML),
        .wdata (wdata),
        .limit (limit),
        .hold  (hold)
    );

    modtmr_count #(.CW(CW)) u_count (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .freeze (freeze),
        .clr    (cnt_clr),
        .limit  (limit),
        .count  (count),
        .wrap   (wrap)
    );

    modtmr_flag u_flag (
        .clk         (clk),
        .rst         (rst),
        .set_ev      (wrap && !hold),
        .rd_stat     (rd_en && addr == RA_STAT),
        .wr_stat     (wr_en && addr == RA_STAT),
        .wr_flag_bit (wdata[FLAG_BIT]),
        .wr_ie_bit   (wdata[IE_BIT]),
        .flag        (flag),
        .ie          (ie)
    );

    assign st  = '{flag: flag, ie: ie, hold: hold};
    assign irq = flag && ie && !hold;

    always_comb begin
        case (addr)
            RA_STAT: rdata = pack_status(st);
            RA_LIMH: rdata = limit[CW-1:BYTE_W];
            RA_LIML: rdata = limit[BYTE_W-1:0];
            RA_CNTH: rdata = count[CW-1:BYTE_W];
            RA_CNTL: rdata = count[BYTE_W-1:0];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk
    import modtmr_pkg::*;
#(
    parameter int CW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic              freeze,
    input logic              cnt_clr,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CW-1:0]     count,
    input logic [CW-1:0]     limit,
    input logic              hold,
    input logic              flag,
    input logic              irq
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (count == '0 && limit == '1 && !flag && !hold));

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && !freeze && !cnt_clr && count == limit) |=> count == '0);

    a_r4_hold_no_set: assert property (@(posedge clk) disable iff (rst)
        (hold && !flag) |=> !flag);

    a_r5_no_irq_in_hold: assert property (@(posedge clk) disable iff (rst)
        hold |-> !irq);

    a_r6_flag_kept: assert property (@(posedge clk) disable iff (rst)
        (flag && !(wr_en && addr == RA_STAT)) |=> flag);

    a_r8_freeze: assert property (@(posedge clk) disable iff (rst)
        (freeze && !cnt_clr) |=> $stable(count));

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (count == '0 && $stable(limit)));
endmodule

bind modtmr_top modtmr_chk #(.CW(2 * modtmr_pkg::BYTE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .freeze  (freeze),
    .cnt_clr (cnt_clr),
    .wr_en   (wr_en),
    .addr    (addr),
    .count   (count),
    .limit   (limit),
    .hold    (hold),
    .flag    (flag),
    .irq     (irq)
);

// File: tb/modtmr_top_tb.sv
module modtmr_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       freeze = 1'b0;
    logic       cnt_clr = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    modtmr_top u_dut (
        .clk(clk), .rst(rst), .tick(tick), .freeze(freeze), .cnt_clr(cnt_clr),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    // vector: limit, ticks, expected count, expected flag
    typedef struct packed {
        logic [15:0] lim;
        logic [15:0] n;
        logic [15:0] exp_cnt;
        logic        exp_flag;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{16'd5,     16'd3,     16'd3, 1'b0},
        '{16'd5,     16'd6,     16'd0, 1'b1},
        '{16'd5,     16'd8,     16'd2, 1'b1},
        '{16'd0,     16'd3,     16'd0, 1'b1},
        '{16'h0102,  16'h0103,  16'd0, 1'b1},
        '{16'h0102,  16'h0100,  16'h0100, 1'b0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic strobe_clr();
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
    endtask

    task automatic read_count(output logic [15:0] c);
        logic [7:0] h, l;
        rd(3'd3, h);
        rd(3'd4, l);
        c = {h, l};
    endtask

    task automatic clear_flag(logic [7:0] keep_ie);
        logic [7:0] s;
        rd(3'd0, s);
        wr(3'd0, keep_ie);
    endtask

    task automatic set_limit(logic [15:0] v);
        wr(3'd1, v[15:8]);
        wr(3'd2, v[7:0]);
    endtask

    initial begin
        logic [7:0]  b;
        logic [15:0] c;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(3'd1, b); check("R1 limh", b, 8'hFF);
        rd(3'd2, b); check("R1 liml", b, 8'hFF);
        read_count(c); check("R1 count", c, 16'h0);
        rd(3'd0, b); check("R1 status", b, 8'h00);
        check("R5 irq reset", irq, 1'b0);

        // R2/R3 table
        foreach (VECS[i]) begin
            set_limit(VECS[i].lim);
            strobe_clr();
            clear_flag(8'h00);
            ticks(int'(VECS[i].n));
            read_count(c);
            check("R2 table count", c, VECS[i].exp_cnt);
            rd(3'd0, b);
            check("R3 table flag", b[7], VECS[i].exp_flag);
        end

        // R6: write 0 without prior read keeps flag (flag set from last-but-one vector? ensure)
        set_limit(16'd3);
        strobe_clr();
        ticks(4);
        wr(3'd0, 8'h00);
        rd(3'd0, b); check("R6 no read keeps flag", b[7], 1'b1);
        wr(3'd0, 8'h00); // armed by previous read -> clears
        rd(3'd0, b); check("R6 read-then-write clears", b[7], 1'b0);
        wr(3'd0, 8'h80);
        rd(3'd0, b); check("R6 writing 1 does not set", b[7], 1'b0);

        // R4 hold window
        strobe_clr();
        wr(3'd1, 8'h00);
        rd(3'd0, b); check("R4 hold bit open", b[5], 1'b1);
        ticks(4);
        read_count(c); check("R4 wraps in hold", c, 16'd0);
        rd(3'd0, b); check("R4 no flag in hold", b[7], 1'b0);
        wr(3'd2, 8'h03);
        rd(3'd0, b); check("R4 hold closed", b[5], 1'b0);
        ticks(4);
        rd(3'd0, b); check("R3 flag after hold", b[7], 1'b1);

        // R5 irq
        check("R5 irq ie=0", irq, 1'b0);
        wr(3'd0, 8'hC0);
        #1 check("R5 irq on", irq, 1'b1);
        wr(3'd1, 8'h00);
        #1 check("R5 irq masked by hold", irq, 1'b0);
        wr(3'd2, 8'h03);
        #1 check("R5 irq back", irq, 1'b1);

        // R7 wrap collides with clearing write
        strobe_clr();
        ticks(3);
        rd(3'd0, b);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd0; wdata = 8'h40; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        rd(3'd0, b); check("R7 set wins", b[7], 1'b1);
        read_count(c); check("R7 wrapped", c, 16'd0);

        // R8 freeze
        ticks(2);
        @(negedge clk);
        freeze = 1'b1; tick = 1'b1;
        repeat (5) @(negedge clk);
        freeze = 1'b0; tick = 1'b0;
        read_count(c); check("R8 frozen", c, 16'd2);

        // R9 clear strobe priority, limit kept
        @(negedge clk);
        cnt_clr = 1'b1; tick = 1'b1; freeze = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0; tick = 1'b0; freeze = 1'b0;
        read_count(c); check("R9 count zero", c, 16'd0);
        rd(3'd1, b); check("R9 limh kept", b, 8'h00);
        rd(3'd2, b); check("R9 liml kept", b, 8'h03);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule